// File: doc/BRIEF.md
# Serial controller flag and interrupt register

This block keeps the run-state and error flags of a serial controller and turns them, together with event levels from the data path, into four interrupt requests. Software never writes a flag word directly. It writes a 16-bit command word in which every flag owns one bit that sets it and one bit that clears it. Any number of flags can change in a single write, and flags whose bits are zero keep their value. No read-modify-write cycle is needed.

The shift engine reports five kinds of error as one-cycle pulses. Each pulse sets its flag only if the matching bit of an error-enable field is 1. A busy level from the shift engine guards the return to configuration mode: a request to drop the enable flag while a transfer runs is held and takes effect in the first idle cycle. Four interrupt-enable bits gate the receive, transmit, error and frame-end requests.

Top module: `serstat_top`

## Requirements
- R1: During reset and in the cycle after it, the status word, the error-enable field, the interrupt-enable field and all four interrupt requests are zero.
- R2: Command bit 1 sets and bit 0 clears the enable flag (status bit 0). Command bit 3 sets and bit 2 clears the master-select flag (status bit 1). A written command shows in the status word on the cycle after the write.
- R3: Command bits 12, 13, 14 and 15 set the transmit-overflow, receive-overflow, abort and transmit-underflow flags (status bits 8, 9, 10, 11). Bits 8 to 11 clear the same four flags in the same order. Bit 5 sets and bit 4 clears receive underflow (status bit 12). Bit 7 sets and bit 6 clears the mode-error flag (status bit 2). Command bits that are zero leave their flags unchanged.
- R4: When a set bit and its clear bit are both 1 in one command, the flag ends up 0.
- R5: The command 0x0F50 clears all five error flags and the mode-error flag in one write, and leaves the enable and master-select flags unchanged.
- R6: A pulse on hw_err[i] (0 transmit overflow, 1 receive overflow, 2 abort, 3 transmit underflow, 4 receive underflow) sets status bit 8+i only when error-enable bit i is 1. Otherwise it has no effect.
- R7: Status bit 13 follows the busy input. A command that clears the enable flag while busy is 1 leaves the flag at 1, and the flag becomes 0 on the first clock edge at which busy is 0.
- R8: irq[0], irq[1] and irq[3] equal the receive, transmit and frame-end source levels ANDed with interrupt-enable bits 0, 1 and 3.
- R9: irq[2] is 1 exactly when interrupt-enable bit 2 is 1 and at least one of status bits 8 to 12 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word, one set bit and one clear bit per flag |
| erren_we | input | 1 | Error-enable field write strobe |
| erren_wdata | input | 5 | New error-enable field, bit i enables hw_err[i] |
| ien_we | input | 1 | Interrupt-enable field write strobe |
| ien_wdata | input | 4 | New interrupt-enable field (0 rx, 1 tx, 2 error, 3 frame end) |
| hw_err | input | 5 | Error pulses from the shift engine |
| busy | input | 1 | Transfer in progress |
| rx_src | input | 1 | Receive request level |
| tx_src | input | 1 | Transmit request level |
| frm_src | input | 1 | Frame-end request level |
| stat_q | output | 16 | Status word |
| erren_q | output | 5 | Current error-enable field |
| ien_q | output | 4 | Current interrupt-enable field |
| irq | output | 4 | Interrupt requests (0 rx, 1 tx, 2 error, 3 frame end) |

## Verification
The properties assume that every input is a clean synchronous level that changes only between clock edges. They also assume that hw_err may pulse in any cycle, including cycles with a command write or a busy period, so the clear-priority and enable-gating properties must hold under overlap. The stimulus drives all inputs on the falling edge and holds busy as a level across several cycles. The bench makes the overlapping cases deliberately: set and clear bits together, a clear-enable command during busy, and error pulses with the error-enable field both zero and partly set.

// File: rtl/serstat_pkg.sv
package serstat_pkg;

   localparam int CMD_W  = 16;
   localparam int STAT_W = 16;
   localparam int NERR   = 5;
   localparam int NIRQ   = 4;
   localparam int NFLAG  = 8;

   // flag slots inside the flag bank
   localparam int F_EN = 0;
   localparam int F_MS = 1;
   localparam int F_ME = 2;
   localparam int F_TE = 3;   // first of the five error flags
   localparam int F_RE = 4;
   localparam int F_AE = 5;
   localparam int F_TU = 6;
   localparam int F_RU = 7;

   // status word positions
   localparam int ST_EN   = 0;
   localparam int ST_MS   = 1;
   localparam int ST_ME   = 2;
   localparam int ST_ERR0 = 8;
   localparam int ST_BUSY = 13;

   // interrupt request positions
   localparam int IRQ_RX  = 0;
   localparam int IRQ_TX  = 1;
   localparam int IRQ_ERR = 2;
   localparam int IRQ_FRM = 3;

   // command bit that sets a flag slot
   function automatic int set_pos(input int f);
      case (f)
         F_EN:    return 1;
         F_MS:    return 3;
         F_ME:    return 7;
         F_RU:    return 5;
         default: return 12 + (f - F_TE);
      endcase
   endfunction

   // command bit that clears a flag slot
   function automatic int clr_pos(input int f);
      case (f)
         F_EN:    return 0;
         F_MS:    return 2;
         F_ME:    return 6;
         F_RU:    return 4;
         default: return 8 + (f - F_TE);
      endcase
   endfunction

endpackage

// File: rtl/serstat_cmd_dec.sv
module serstat_cmd_dec
   import serstat_pkg::*;
#(
   parameter int CW = CMD_W,
   parameter int NF = NFLAG
) (
   input  logic          we,
   input  logic [CW-1:0] data,
   output logic [NF-1:0] set_v,
   output logic [NF-1:0] clr_v
);

   generate
      if (CW != 16) begin : g_bad_cw
         $error("serstat_cmd_dec: command word must be 16 bits");
      end
      if (NF != NFLAG) begin : g_bad_nf
         $error("serstat_cmd_dec: flag count must match the package");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NF; i++) begin : g_dec
         localparam int SP = set_pos(i);
         localparam int CP = clr_pos(i);
         assign set_v[i] = we & data[SP];
         assign clr_v[i] = we & data[CP];
      end
   endgenerate

endmodule

// File: rtl/serstat_flag_bank.sv
module serstat_flag_bank
   import serstat_pkg::*;
#(
   parameter int NF     = NFLAG,
   parameter int GATED  = F_EN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic [NF-1:0] cmd_set,
   input  logic [NF-1:0] cmd_clr,
   input  logic [NF-1:0] hw_set,
   output logic [NF-1:0] q
);

   generate
      if (GATED < 0 || GATED >= NF) begin : g_bad_gated
         $error("serstat_flag_bank: gated slot out of range");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         logic set_any;
         assign set_any = cmd_set[i] | hw_set[i];

         if (i == GATED) begin : g_busy_gated
            // clear request waits until the engine is idle
            logic pend_q;
            logic clr_now;
            assign clr_now = (cmd_clr[i] | pend_q) & ~busy;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pend_q <= 1'b0;
               end else if (busy) begin
                  pend_q <= pend_q | cmd_clr[i];
               end else begin
                  pend_q <= 1'b0;
               end
            end

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q[i] <= 1'b0;
               end else if (clr_now) begin
                  q[i] <= 1'b0;
               end else if (set_any) begin
                  q[i] <= 1'b1;
               end
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q[i] <= 1'b0;
               end else if (cmd_clr[i]) begin
                  q[i] <= 1'b0;
               end else if (set_any) begin
                  q[i] <= 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/serstat_irq.sv
module serstat_irq
   import serstat_pkg::*;
#(
   parameter int NI = NIRQ
) (
   input  logic          err_any,
   input  logic          rx_src,
   input  logic          tx_src,
   input  logic          frm_src,
   input  logic [NI-1:0] ien,
   output logic [NI-1:0] irq
);

   generate
      if (NI != 4) begin : g_bad_ni
         $error("serstat_irq: exactly four request lines are supported");
      end
   endgenerate

   logic [NI-1:0] src;

   always_comb begin
      src          = '0;
      src[IRQ_RX]  = rx_src;
      src[IRQ_TX]  = tx_src;
      src[IRQ_ERR] = err_any;
      src[IRQ_FRM] = frm_src;
   end

   generate
      for (genvar i = 0; i < NI; i++) begin : g_gate
         assign irq[i] = src[i] & ien[i];
      end
   endgenerate

endmodule

// File: rtl/serstat_top.sv
module serstat_top
   import serstat_pkg::*;
#(
   parameter int CW = CMD_W,
   parameter int SW = STAT_W,
   parameter int NE = NERR,
   parameter int NI = NIRQ
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic [CW-1:0] cmd_data,
   input  logic          erren_we,
   input  logic [NE-1:0] erren_wdata,
   input  logic          ien_we,
   input  logic [NI-1:0] ien_wdata,
   input  logic [NE-1:0] hw_err,
   input  logic          busy,
   input  logic          rx_src,
   input  logic          tx_src,
   input  logic          frm_src,
   output logic [SW-1:0] stat_q,
   output logic [NE-1:0] erren_q,
   output logic [NI-1:0] ien_q,
   output logic [NI-1:0] irq
);

   localparam int NF = NFLAG;

   generate
      if (NE != NERR) begin : g_bad_ne
         $error("serstat_top: five error kinds are required");
      end
      if (SW <= ST_BUSY) begin : g_bad_sw
         $error("serstat_top: status word too narrow");
      end
      if (ST_ERR0 + NE > ST_BUSY) begin : g_bad_map
         $error("serstat_top: error field overlaps busy bit");
      end
   endgenerate

   logic [NF-1:0] cmd_set;
   logic [NF-1:0] cmd_clr;
   logic [NF-1:0] hw_set;
   logic [NF-1:0] flags;
   logic          err_any;

   // configuration fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erren_q <= '0;
      end else if (erren_we) begin
         erren_q <= erren_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (ien_we) begin
         ien_q <= ien_wdata;
      end
   end

   serstat_cmd_dec #(.CW(CW), .NF(NF)) u_dec (
      .we    (cmd_we),
      .data  (cmd_data),
      .set_v (cmd_set),
      .clr_v (cmd_clr)
   );

   // hardware error pulses reach only the error slots, each behind its enable
   always_comb begin
      hw_set = '0;
      for (int i = 0; i < NE; i++) begin
         hw_set[F_TE + i] = hw_err[i] & erren_q[i];
      end
   end

   serstat_flag_bank #(.NF(NF), .GATED(F_EN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .cmd_set (cmd_set),
      .cmd_clr (cmd_clr),
      .hw_set  (hw_set),
      .q       (flags)
   );

   assign err_any = |flags[F_TE +: NE];

   always_comb begin
      stat_q                 = '0;
      stat_q[ST_EN]          = flags[F_EN];
      stat_q[ST_MS]          = flags[F_MS];
      stat_q[ST_ME]          = flags[F_ME];
      stat_q[ST_ERR0 +: NE]  = flags[F_TE +: NE];
      stat_q[ST_BUSY]        = busy;
   end

   serstat_irq #(.NI(NI)) u_irq (
      .err_any (err_any),
      .rx_src  (rx_src),
      .tx_src  (tx_src),
      .frm_src (frm_src),
      .ien     (ien_q),
      .irq     (irq)
   );

endmodule

// File: rtl/serstat_chk.sv
module serstat_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_we,
   input logic [15:0] cmd_data,
   input logic        busy,
   input logic [4:0]  erren_q,
   input logic [3:0]  ien_q,
   input logic [15:0] stat_q,
   input logic [3:0]  irq
);

   a_r2_ms_set: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data[3] && !cmd_data[2] |=> stat_q[1]);

   a_r4_en_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data[0] && cmd_data[1] && !busy |=> !stat_q[0]);

   a_r5_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && cmd_data == 16'h0F50 |=> stat_q[12:8] == 5'd0 && !stat_q[2]);

   a_r6_gated_hw_error: assert property (@(posedge clk) disable iff (!rst_n)
      !erren_q[0] && !(cmd_we && cmd_data[12]) && !stat_q[8] |=> !stat_q[8]);

   a_r7_busy_holds_en: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stat_q[0] |=> stat_q[0]);

   a_r9_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq[2] == ((|stat_q[12:8]) && ien_q[2]));

endmodule

bind serstat_top serstat_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_we   (cmd_we),
   .cmd_data (cmd_data),
   .busy     (busy),
   .erren_q  (erren_q),
   .ien_q    (ien_q),
   .stat_q   (stat_q),
   .irq      (irq)
);

// File: tb/serstat_top_bench.sv
module serstat_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_data = '0;
   logic        erren_we = 1'b0;
   logic [4:0]  erren_wdata = '0;
   logic        ien_we = 1'b0;
   logic [3:0]  ien_wdata = '0;
   logic [4:0]  hw_err = '0;
   logic        busy = 1'b0;
   logic        rx_src = 1'b0;
   logic        tx_src = 1'b0;
   logic        frm_src = 1'b0;
   logic [15:0] stat_q;
   logic [4:0]  erren_q;
   logic [3:0]  ien_q;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   serstat_top u_serstat_top (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .erren_we(erren_we), .erren_wdata(erren_wdata), .ien_we(ien_we),
      .ien_wdata(ien_wdata), .hw_err(hw_err), .busy(busy), .rx_src(rx_src),
      .tx_src(tx_src), .frm_src(frm_src), .stat_q(stat_q), .erren_q(erren_q),
      .ien_q(ien_q), .irq(irq)
   );

   // {command, expected status, requirement number}
   localparam int NVEC = 14;
   localparam logic [39:0] VEC [NVEC] = '{
      {16'h0002, 16'h0001, 8'd2},   // R2 set enable
      {16'h0008, 16'h0003, 8'd2},   // R2 set master select
      {16'hF000, 16'h0F03, 8'd3},   // R3 set four error flags
      {16'h0020, 16'h1F03, 8'd3},   // R3 set receive underflow
      {16'h0080, 16'h1F07, 8'd3},   // R3 set mode error
      {16'h0F50, 16'h0003, 8'd5},   // R5 bulk clear
      {16'h3000, 16'h0303, 8'd3},   // R3 two error flags
      {16'h1100, 16'h0203, 8'd4},   // R4 set+clear transmit overflow
      {16'h000C, 16'h0201, 8'd4},   // R4 set+clear master select
      {16'h0003, 16'h0200, 8'd4},   // R4 set+clear enable
      {16'h8000, 16'h0A00, 8'd3},   // R3 set transmit underflow
      {16'h0000, 16'h0A00, 8'd3},   // R3 empty command changes nothing
      {16'h0800, 16'h0200, 8'd3},   // R3 clear transmit underflow
      {16'h0200, 16'h0000, 8'd3}    // R3 clear receive overflow
   };

   task automatic check(input int req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [15:0] v);
      @(negedge clk);
      cmd_we = 1'b1;
      cmd_data = v;
      @(negedge clk);
      cmd_we = 1'b0;
      cmd_data = '0;
   endtask

   task automatic pulse_err(input logic [4:0] v);
      @(negedge clk);
      hw_err = v;
      @(negedge clk);
      hw_err = '0;
   endtask

   task automatic set_erren(input logic [4:0] v);
      @(negedge clk);
      erren_we = 1'b1;
      erren_wdata = v;
      @(negedge clk);
      erren_we = 1'b0;
   endtask

   task automatic set_ien(input logic [3:0] v);
      @(negedge clk);
      ien_we = 1'b1;
      ien_wdata = v;
      @(negedge clk);
      ien_we = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rx_src = 1'b1; tx_src = 1'b1; frm_src = 1'b1;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(1, "status in reset", stat_q, 16'h0000);
      check(1, "irq in reset", {12'd0, irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "status after reset", stat_q, 16'h0000);
      check(1, "enables after reset", {7'd0, erren_q, ien_q}, 16'h0000);
      rx_src = 1'b0; tx_src = 1'b0; frm_src = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         do_cmd(VEC[i][39:24]);
         check(int'(VEC[i][7:0]), "command vector", stat_q, VEC[i][23:8]);
      end

      // R6 hardware errors with all enables off are ignored
      pulse_err(5'b11111);
      check(6, "hw error while disabled", stat_q, 16'h0000);
      set_erren(5'b10001);
      check(6, "error enable readback", {11'd0, erren_q}, 16'h0011);
      pulse_err(5'b11111);
      check(6, "hw error partly enabled", stat_q, 16'h1100);
      do_cmd(16'h0F50);
      check(5, "bulk clear after hw errors", stat_q, 16'h0000);

      // R7 clear-enable held while busy
      do_cmd(16'h0002);
      check(2, "enable set", stat_q, 16'h0001);
      @(negedge clk);
      busy = 1'b1;
      do_cmd(16'h0001);
      check(7, "enable kept while busy", stat_q, 16'h2001);
      repeat (3) @(negedge clk);
      check(7, "enable still kept", stat_q, 16'h2001);
      busy = 1'b0;
      @(negedge clk);
      check(7, "pending clear applied", stat_q, 16'h0000);

      // R8 source gating
      set_ien(4'b1011);
      rx_src = 1'b1; tx_src = 1'b0; frm_src = 1'b1;
      @(negedge clk);
      check(8, "rx and frame requests", {12'd0, irq}, 16'h0009);
      do_cmd(16'h1000);
      check(9, "error irq masked", {12'd0, irq}, 16'h0009);
      set_ien(4'b0100);
      check(9, "error irq raised", {12'd0, irq}, 16'h0004);
      do_cmd(16'h0F50);
      check(9, "error irq dropped", {12'd0, irq}, 16'h0000);
      tx_src = 1'b1;
      set_ien(4'b0010);
      check(8, "tx request", {12'd0, irq}, 16'h0002);

      // R1 reset in the middle of operation
      do_cmd(16'hF00A);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, "status after second reset", stat_q, 16'h0000);
      check(1, "irq after second reset", {12'd0, irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule